// File: doc/BRIEF.md
# Sidetone Coefficient-Load Register Interface

This block is the software-facing register front end of a sidetone filter core. It sits on a plain 32-bit register bus with address, write strobe, read strobe, write data and read data. It keeps the core's configuration: the clock auto-idle request, the two signed channel gains and a control word with the sidetone enable. It also owns the filter's coefficient memory, which holds 128 signed 16-bit entries. The filter datapath reads that memory through a separate index/data port.

Software loads coefficients through a single data register that cannot be read back. It sets the coefficient write-enable bit in the control register, which rewinds a hidden pointer. It then writes the 128 coefficients to the data register one after another, and the pointer advances on each accepted write. Once the last entry is stored, a read-only done bit comes up. Software then clears write-enable. While a load is open and not yet finished, the filter-valid output stays low, so the datapath never runs on a half-written coefficient set.

Top module: `sidetone_coef_regs`

## Requirements
- R1: After reset, the system configuration register reads 1 (auto-idle set). The gain and control registers read 0, every coefficient entry reads 0, and auto_idle_o=1, st_enable_o=0, filter_valid_o=0.
- R2: Offset 0x10 is the system configuration register. Bit 0 is auto-idle: it is read/write and drives auto_idle_o. All other bits read 0.
- R3: Offset 0x24 is the gain register. Bits 15:0 hold the channel 0 gain and bits 31:16 hold the channel 1 gain. Both read back and appear on gain0_o and gain1_o.
- R4: Offset 0x2C is the control register. Bit 0 is the sidetone enable and drives st_enable_o. Bit 1 is the coefficient write-enable. Bit 2 is the done flag: it reads back but software writes to it are ignored.
- R5: Offset 0x00 returns the REV_ID parameter and ignores writes. The coefficient data register (0x28) and the offsets 0x18 and 0x1C read 0.
- R6: While write-enable is 1 and done is 0, each write to 0x28 stores wdata[15:0] at the current pointer, and the pointer then advances by one.
- R7: After the 128th accepted coefficient write, done reads 1. Further coefficient writes change no entry until the next arming.
- R8: Coefficient writes while write-enable is 0 change no entry.
- R9: A control write that takes write-enable from 0 to 1 resets the pointer to entry 0 and clears done. A control write that leaves write-enable at 1 does not move the pointer.
- R10: A control write that clears write-enable also clears done.
- R11: filter_valid_o is 1 exactly when enable is 1 and no load is open (write-enable is 0, or done is 1).
- R12: A read returns its data on rdata_o in the cycle after rd_en_i. rdata_o holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| coef_idx_i | input | log2(TAPS) | Coefficient read index from the filter |
| coef_o | output | COEF_W | Coefficient at coef_idx_i |
| gain0_o | output | COEF_W | Channel 0 gain |
| gain1_o | output | COEF_W | Channel 1 gain |
| st_enable_o | output | 1 | Sidetone enable |
| auto_idle_o | output | 1 | Clock auto-idle request |
| filter_valid_o | output | 1 | Filter may run on the stored coefficients |

## Verification
The hardest states to reach from the ports are the ones at the edges of a load. One is the cycle after the 128th write, when the pointer must stop and further data must be dropped. The other is a repeated arming write while a load is only partly done. The stimulus splits a full load into 100 writes and then 28 writes, with a control write that keeps write-enable at 1 between the two parts. It then sends an extra write past the end. Finally it disarms, re-arms and writes two entries, and checks that only entries 0 and 1 changed while entry 2 kept its old value.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;
  localparam int unsigned OFF_REV   = 'h00;
  localparam int unsigned OFF_SYS   = 'h10;
  localparam int unsigned OFF_IRQS  = 'h18;
  localparam int unsigned OFF_IRQE  = 'h1C;
  localparam int unsigned OFF_GAIN  = 'h24;
  localparam int unsigned OFF_COEF  = 'h28;
  localparam int unsigned OFF_CTRL  = 'h2C;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_WE_BIT   = 1;
  localparam int unsigned CTRL_DONE_BIT = 2;

  typedef struct packed {
    logic done;
    logic we;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/sidetone_coef_loader.sv
module sidetone_coef_loader #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 128,
  localparam int unsigned PTR_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              arm_set_i,
  input  logic              arm_clr_i,
  input  logic              coef_wr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [COEF_W-1:0] rd_data_o,
  output logic              done_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TAPS - 1);

  logic [COEF_W-1:0] mem_q [TAPS];
  logic [PTR_W-1:0]  ptr_q;
  logic              done_q;
  logic              accept;

  assign accept = coef_wr_i && we_i && !done_q && !arm_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else if (arm_set_i) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else if (arm_clr_i) begin
      done_q <= 1'b0;
    end else if (accept) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (accept) begin
      mem_q[ptr_q] <= coef_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign done_o    = done_q;

  assert_done_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ptr_q == LAST) |=> done_o);
  assert_hold_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_set_i) |=> $stable(ptr_q));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !arm_set_i) |=> $stable(ptr_q));
  assert_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_set_i |=> (ptr_q == '0 && !done_o));
  assert_clr_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_clr_i |=> !done_o);
endmodule

// File: rtl/sidetone_ctrl_regs.sv
module sidetone_ctrl_regs
  import sidetone_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned COEF_W = 16,
  parameter logic [31:0] REV_ID = 32'h0000_0021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              done_i,
  output logic [31:0]       rdata_o,
  output logic              coef_wr_o,
  output logic              arm_set_o,
  output logic              arm_clr_o,
  output logic              we_o,
  output logic              en_o,
  output logic              auto_idle_o,
  output logic [COEF_W-1:0] gain0_o,
  output logic [COEF_W-1:0] gain1_o
);
  logic              auto_idle_q, en_q, we_q;
  logic [COEF_W-1:0] g0_q, g1_q;
  logic              wr_sys, wr_gain, wr_ctrl;
  logic [31:0]       rd_mux;
  ctrl_t             ctrl_view;

  assign wr_sys    = wr_en_i && addr_i == ADDR_W'(OFF_SYS);
  assign wr_gain   = wr_en_i && addr_i == ADDR_W'(OFF_GAIN);
  assign wr_ctrl   = wr_en_i && addr_i == ADDR_W'(OFF_CTRL);
  assign coef_wr_o = wr_en_i && addr_i == ADDR_W'(OFF_COEF);
  assign arm_set_o = wr_ctrl && wdata_i[CTRL_WE_BIT] && !we_q;
  assign arm_clr_o = wr_ctrl && !wdata_i[CTRL_WE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_idle_q <= 1'b1;
      en_q        <= 1'b0;
      we_q        <= 1'b0;
      g0_q        <= '0;
      g1_q        <= '0;
    end else begin
      if (wr_sys) auto_idle_q <= wdata_i[0];
      if (wr_gain) begin
        g0_q <= wdata_i[COEF_W-1:0];
        g1_q <= wdata_i[16 +: COEF_W];
      end
      if (wr_ctrl) begin
        en_q <= wdata_i[CTRL_EN_BIT];
        we_q <= wdata_i[CTRL_WE_BIT];
      end
    end
  end

  assign ctrl_view = '{done: done_i, we: we_q, en: en_q};

  always_comb begin
    rd_mux = '0;
    unique case (int'(addr_i))
      OFF_REV:  rd_mux = REV_ID;
      OFF_SYS:  rd_mux = {31'b0, auto_idle_q};
      OFF_GAIN: rd_mux = {g1_q, g0_q};
      OFF_CTRL: rd_mux = {29'b0, ctrl_view};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign we_o        = we_q;
  assign en_o        = en_q;
  assign auto_idle_o = auto_idle_q;
  assign gain0_o     = g0_q;
  assign gain1_o     = g1_q;

  assert_autoidle_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sys |=> auto_idle_o == $past(wdata_i[0]));
  assert_gain_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gain |=> (gain0_o == $past(wdata_i[15:0]) && gain1_o == $past(wdata_i[31:16])));
  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/sidetone_coef_regs.sv
module sidetone_coef_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 128,
  parameter logic [31:0] REV_ID = 32'h0000_0021,
  localparam int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [IDX_W-1:0]  coef_idx_i,
  output logic [COEF_W-1:0] coef_o,
  output logic [COEF_W-1:0] gain0_o,
  output logic [COEF_W-1:0] gain1_o,
  output logic              st_enable_o,
  output logic              auto_idle_o,
  output logic              filter_valid_o
);
  logic coef_wr, arm_set, arm_clr, we, en, done;

  sidetone_ctrl_regs #(.ADDR_W(ADDR_W), .COEF_W(COEF_W), .REV_ID(REV_ID)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .done_i(done), .rdata_o, .coef_wr_o(coef_wr), .arm_set_o(arm_set),
    .arm_clr_o(arm_clr), .we_o(we), .en_o(en), .auto_idle_o,
    .gain0_o, .gain1_o
  );

  sidetone_coef_loader #(.COEF_W(COEF_W), .TAPS(TAPS)) u_loader (
    .clk_i, .rst_ni, .we_i(we), .arm_set_i(arm_set), .arm_clr_i(arm_clr),
    .coef_wr_i(coef_wr), .coef_data_i(wdata_i[COEF_W-1:0]),
    .rd_idx_i(coef_idx_i), .rd_data_o(coef_o), .done_o(done)
  );

  assign st_enable_o    = en;
  assign filter_valid_o = en && (!we || done);

  assert_valid_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && !done) |-> !filter_valid_o);
endmodule

// File: tb/tb_sidetone_coef_regs.sv
module tb_sidetone_coef_regs;
  localparam int unsigned TAPS = 128;
  localparam logic [31:0] REV = 32'h0000_0021;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  cidx = '0;
  logic [15:0] coef, g0, g1;
  logic        st_en, aidle, fvalid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sidetone_coef_regs #(.REV_ID(REV)) dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .coef_idx_i(cidx), .coef_o(coef),
    .gain0_o(g0), .gain1_o(g1), .st_enable_o(st_en), .auto_idle_o(aidle),
    .filter_valid_o(fvalid)
  );

  function automatic logic [15:0] cval(int i);
    return 16'((i * 373 + 11)) ^ 16'h5a5a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_coef(int i, logic [15:0] exp, string req);
    cidx = 7'(i);
    #1;
    check(req, {16'b0, coef}, {16'b0, exp});
  endtask

  // monitor: compare registered read data one cycle after the strobe (R12)
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 auto_idle", {31'b0, aidle}, 32'h1);
    check("R1 valid", {31'b0, fvalid}, 32'h0);
    check("R1 enable", {31'b0, st_en}, 32'h0);
    chk_coef(5, 16'h0, "R1 coef");
    rd(8'h10, 32'h1, "R1 sysconfig");
    rd(8'h24, 32'h0, "R1 gain");
    rd(8'h2C, 32'h0, "R1 ctrl");
    rd(8'h00, REV, "R5 revision");
    // R2 auto-idle
    wr(8'h10, 32'hFFFF_FFFE);
    rd(8'h10, 32'h0, "R2 sysconfig clear");
    check("R2 auto_idle_o low", {31'b0, aidle}, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h1, "R2 sysconfig set");
    // R3 gains
    wr(8'h24, 32'h8001_7FFF);
    rd(8'h24, 32'h8001_7FFF, "R3 gain readback");
    check("R3 gain0", {16'b0, g0}, 32'h7FFF);
    check("R3 gain1", {16'b0, g1}, 32'h8001);
    // R4 enable, done not writable
    wr(8'h2C, 32'h5);
    rd(8'h2C, 32'h1, "R4 ctrl done ro");
    check("R4 st_enable_o", {31'b0, st_en}, 32'h1);
    check("R11 valid idle", {31'b0, fvalid}, 32'h1);
    // R8 writes while disarmed
    wr(8'h28, 32'h0000_1234);
    chk_coef(0, 16'h0, "R8 ignored");
    // R6 arm and partial load
    wr(8'h2C, 32'h3);
    check("R11 valid low during load", {31'b0, fvalid}, 32'h0);
    for (int i = 0; i < 100; i++) wr(8'h28, {16'hABCD, cval(i)});
    rd(8'h2C, 32'h3, "R7 not done at 100");
    // R9 re-write with we kept 1: pointer continues
    wr(8'h2C, 32'h3);
    for (int i = 100; i < TAPS; i++) wr(8'h28, {16'h0, cval(i)});
    rd(8'h2C, 32'h7, "R7 done after 128");
    check("R11 valid after done", {31'b0, fvalid}, 32'h1);
    for (int i = 0; i < TAPS; i += 9) chk_coef(i, cval(i), "R6 coef stored");
    chk_coef(127, cval(127), "R6 last coef");
    // R7 extra write ignored
    wr(8'h28, 32'h0000_DEAD);
    chk_coef(0, cval(0), "R7 entry0 kept");
    chk_coef(127, cval(127), "R7 entry127 kept");
    // R10 clearing we clears done
    wr(8'h2C, 32'h1);
    rd(8'h2C, 32'h1, "R10 done cleared");
    // R9 restart
    wr(8'h2C, 32'h3);
    rd(8'h2C, 32'h3, "R9 rearm done low");
    wr(8'h28, 32'h0000_1111);
    wr(8'h28, 32'h0000_2222);
    chk_coef(0, 16'h1111, "R9 restart entry0");
    chk_coef(1, 16'h2222, "R9 restart entry1");
    chk_coef(2, cval(2), "R9 entry2 old");
    // R5 fixed / zero registers
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, REV, "R5 revision ro");
    rd(8'h28, 32'h0, "R5 coef reads zero");
    rd(8'h18, 32'h0, "R5 irq status zero");
    rd(8'h1C, 32'h0, "R5 irq enable zero");
    // R11 disabled
    wr(8'h2C, 32'h0);
    check("R11 valid when disabled", {31'b0, fvalid}, 32'h0);
    // R12 hold between reads
    rd(8'h24, 32'h8001_7FFF, "R12 read gain");
    repeat (3) @(negedge clk);
    check("R12 rdata holds", rdata, 32'h8001_7FFF);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule